// File: doc/BRIEF.md
# IN Endpoint Bank Abort Sequencer

This block cancels whatever an IN endpoint still holds for transmission. The endpoint keeps a small ring of banks, each holding one data word. The CPU side commits filled banks into the ring, and the host side pops the oldest one. When the CPU raises an abort, the sequencer first masks the endpoint's transmit-ready interrupt enable. It then looks at how many banks are still occupied.

While banks remain, the sequencer fires a kill strobe into the bank manager. The bank manager latches it as a kill request. That request drops the newest committed bank, and the request reads back set until the discard has finished. The sequencer waits for the request to clear, then checks the occupancy again. It repeats this until the ring is empty, then reports completion with a one-cycle done pulse and goes back to idle.

The bank manager included here is a complete, synthesizable model of the bank ring. The testbench drives the block through it.

Top module: `txab_top`

## Requirements
- R1: Accepting an abort clears `txrdy_ien`; it reads 0 one cycle after the accepting edge and stays 0 until the abort ends. While idle, `ien_set` sets `txrdy_ien` at the next edge. During an abort, `ien_set` has no effect.
- R2: An abort accepted with `busy_cnt` = 0 raises `abort_done` exactly 2 cycles after the accepting edge, with no kill issued.
- R3: An abort accepted with `busy_cnt` = n > 0 issues one kill per bank. `abort_done` rises exactly 2 + 5·n cycles after the accepting edge.
- R4: Each kill holds `kill_pend` high for two cycles. `busy_cnt` drops by one at the first of those cycles. `kill_pend` clears one cycle after the decrement.
- R5: A kill removes the most recently committed bank. Kills repeat until `busy_cnt` is 0, and `busy_cnt` is 0 whenever `abort_done` is high.
- R6: While `abort_busy` is high, `bank_commit` is ignored: `busy_cnt` never rises and nothing is stored.
- R7: `abort_done` is high for exactly one cycle. In the following cycle `abort_busy` is low and a new abort can be accepted.
- R8: The ring holds NBANKS words. A commit is accepted only when `busy_cnt` < NBANKS. A pop is accepted only when `busy_cnt` > 0 and no kill is pending. An accepted pop presents the oldest word on `tx_data` with `tx_valid` high in the next cycle. Order is preserved across aborts.
- R9: After reset, `busy_cnt`, `txrdy_ien`, `kill_pend`, `abort_busy`, `abort_done` and `tx_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_req | input | 1 | Abort request, sampled while idle |
| ien_set | input | 1 | Sets the transmit-ready interrupt enable |
| bank_commit | input | 1 | Commit `bank_wdata` as a new filled bank |
| bank_wdata | input | DW | Word for the committed bank |
| host_pop | input | 1 | Host takes the oldest bank |
| tx_data | output | DW | Word taken by the last accepted pop |
| tx_valid | output | 1 | `tx_data` is valid (one cycle per pop) |
| busy_cnt | output | $clog2(NBANKS+1) | Number of occupied banks |
| txrdy_ien | output | 1 | Transmit-ready interrupt enable |
| kill_pend | output | 1 | Kill request read-back |
| abort_busy | output | 1 | Abort sequence in progress |
| abort_done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a CPU commit arriving while kills are in flight. It could slip a new bank behind a discard, and it would only show up later as a wrong word or a wrong order. The stimulus holds `bank_commit` high with fresh data for the whole abort. After the abort it commits known words and pops them, so that any stray store or misplaced write pointer appears in `tx_data`. Random sequences of commits, pops, enable writes and aborts from a fixed seed then reach aborts at every ring occupancy. Each abort's done latency is compared with 2 + 5·n.

// File: rtl/txab_pkg.sv
package txab_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_MASK  = 3'd1,
    SQ_CHECK = 3'd2,
    SQ_ARM   = 3'd3,
    SQ_WAIT  = 3'd4
  } txab_state_e;
endpackage

// File: rtl/txab_bank_mgr.sv
module txab_bank_mgr #(
  parameter int NBANKS = 2,
  parameter int DW     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         commit,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  input  logic                         kill_set,
  output logic [DW-1:0]                rdata,
  output logic                         rvalid,
  output logic [$clog2(NBANKS+1)-1:0]  cnt,
  output logic                         kill_req
);
  localparam int CW = $clog2(NBANKS + 1);
  localparam int PW = (NBANKS > 1) ? $clog2(NBANKS) : 1;
  localparam logic [CW-1:0] FULL = CW'(NBANKS);
  localparam logic [PW-1:0] LAST = PW'(NBANKS - 1);

  logic [DW-1:0] mem [NBANKS];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          kill_ph;
  logic          wr_fire, rd_fire, kill_dec;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
    return (p == '0) ? LAST : p - PW'(1);
  endfunction

  assign wr_fire  = commit && (cnt < FULL) && !kill_req;
  assign rd_fire  = pop && (cnt != '0) && !kill_req;
  assign kill_dec = kill_req && !kill_ph && (cnt != '0);

  // storage: write port and registered read port, no reset
  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr] <= wdata;
    if (rd_fire) rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      rvalid   <= 1'b0;
      kill_req <= 1'b0;
      kill_ph  <= 1'b0;
    end else begin
      rvalid <= rd_fire;
      if (kill_req) begin
        if (!kill_ph) begin
          kill_ph <= 1'b1;
          if (kill_dec) begin
            cnt    <= cnt - CW'(1);
            wr_ptr <= ptr_dec(wr_ptr);
          end
        end else begin
          kill_ph  <= 1'b0;
          kill_req <= 1'b0;
        end
      end else begin
        if (kill_set) kill_req <= 1'b1;
        if (wr_fire) wr_ptr <= ptr_inc(wr_ptr);
        if (rd_fire) rd_ptr <= ptr_inc(rd_ptr);
        if (wr_fire && !rd_fire)      cnt <= cnt + CW'(1);
        else if (rd_fire && !wr_fire) cnt <= cnt - CW'(1);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL); // R8
  AST_KILL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    $rose(kill_req) |=> kill_req); // R4
  AST_CNT_FROZEN_IN_KILL: assert property (@(posedge clk) disable iff (rst)
    $past(kill_req) && kill_req |-> cnt <= $past(cnt)); // R5
endmodule

// File: rtl/txab_seq.sv
module txab_seq
  import txab_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort_req,
  input  logic          ien_set,
  input  logic [CW-1:0] busy_cnt,
  input  logic          kill_req,
  output logic          kill_set,
  output logic          txrdy_ien,
  output logic          abort_busy,
  output logic          abort_done
);
  txab_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      kill_set   <= 1'b0;
      txrdy_ien  <= 1'b0;
      abort_busy <= 1'b0;
      abort_done <= 1'b0;
    end else begin
      kill_set   <= 1'b0;
      abort_done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (abort_req) begin
            state      <= SQ_MASK;
            abort_busy <= 1'b1;
          end else if (ien_set) begin
            txrdy_ien <= 1'b1;
          end
        end
        SQ_MASK: begin
          txrdy_ien <= 1'b0;
          state     <= SQ_CHECK;
        end
        SQ_CHECK: begin
          if (busy_cnt == '0) begin
            state      <= SQ_IDLE;
            abort_busy <= 1'b0;
            abort_done <= 1'b1;
          end else begin
            kill_set <= 1'b1;
            state    <= SQ_ARM;
          end
        end
        SQ_ARM:  if (kill_req)  state <= SQ_WAIT;
        SQ_WAIT: if (!kill_req) state <= SQ_CHECK;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_MASKED_IN_LOOP: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_CHECK || state == SQ_ARM || state == SQ_WAIT) |-> !txrdy_ien); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    abort_done |=> !abort_done && !abort_busy); // R7
endmodule

// File: rtl/txab_top.sv
module txab_top #(
  parameter int NBANKS = 2,
  parameter int DW     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        abort_req,
  input  logic                        ien_set,
  input  logic                        bank_commit,
  input  logic [DW-1:0]               bank_wdata,
  input  logic                        host_pop,
  output logic [DW-1:0]               tx_data,
  output logic                        tx_valid,
  output logic [$clog2(NBANKS+1)-1:0] busy_cnt,
  output logic                        txrdy_ien,
  output logic                        kill_pend,
  output logic                        abort_busy,
  output logic                        abort_done
);
  localparam int CW = $clog2(NBANKS + 1);

  logic kill_set;
  logic commit_ok;

  assign commit_ok = bank_commit && !abort_busy;

  txab_seq #(.CW(CW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .abort_req  (abort_req),
    .ien_set    (ien_set),
    .busy_cnt   (busy_cnt),
    .kill_req   (kill_pend),
    .kill_set   (kill_set),
    .txrdy_ien  (txrdy_ien),
    .abort_busy (abort_busy),
    .abort_done (abort_done)
  );

  txab_bank_mgr #(.NBANKS(NBANKS), .DW(DW)) u_banks (
    .clk      (clk),
    .rst      (rst),
    .commit   (commit_ok),
    .wdata    (bank_wdata),
    .pop      (host_pop),
    .kill_set (kill_set),
    .rdata    (tx_data),
    .rvalid   (tx_valid),
    .cnt      (busy_cnt),
    .kill_req (kill_pend)
  );

  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    abort_done |-> busy_cnt == '0); // R5
  AST_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
    abort_busy && $past(abort_busy) |-> busy_cnt <= $past(busy_cnt)); // R6
  AST_KILL_IN_ABORT: assert property (@(posedge clk) disable iff (rst)
    kill_set |-> abort_busy); // R3
endmodule

// File: tb/txab_top_test.sv
module txab_top_test;
  localparam int NB = 2;
  localparam int DW = 8;
  localparam int CW = $clog2(NB + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic abort_req = 1'b0, ien_set = 1'b0, bank_commit = 1'b0, host_pop = 1'b0;
  logic [DW-1:0] bank_wdata = '0;
  logic [DW-1:0] tx_data;
  logic tx_valid, txrdy_ien, kill_pend, abort_busy, abort_done;
  logic [CW-1:0] busy_cnt;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  int mq [NB];
  int mcnt = 0;

  always #2 clk = ~clk;

  txab_top #(.NBANKS(NB), .DW(DW)) uut (
    .clk(clk), .rst(rst), .abort_req(abort_req), .ien_set(ien_set),
    .bank_commit(bank_commit), .bank_wdata(bank_wdata), .host_pop(host_pop),
    .tx_data(tx_data), .tx_valid(tx_valid), .busy_cnt(busy_cnt),
    .txrdy_ien(txrdy_ien), .kill_pend(kill_pend), .abort_busy(abort_busy),
    .abort_done(abort_done)
  );

  function automatic int done_latency(input int n);
    return 2 + 5 * n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_commit(input int d);
    bank_commit = 1'b1;
    bank_wdata  = DW'(d);
    step();
    bank_commit = 1'b0;
    if (mcnt < NB) begin
      mq[mcnt] = d & 8'hFF;
      mcnt++;
    end
    check(int'(busy_cnt) == mcnt, "R8 commit count", int'(busy_cnt), mcnt);
  endtask

  task automatic do_pop();
    int had = mcnt;
    host_pop = 1'b1;
    step();
    host_pop = 1'b0;
    if (had > 0) begin
      check(tx_valid == 1'b1, "R8 pop valid", int'(tx_valid), 1);
      check(int'(tx_data) == mq[0], "R8 pop oldest word", int'(tx_data), mq[0]);
      for (int i = 0; i < NB - 1; i++) mq[i] = mq[i+1];
      mcnt--;
    end else begin
      check(tx_valid == 1'b0, "R8 empty pop ignored", int'(tx_valid), 0);
    end
    check(int'(busy_cnt) == mcnt, "R8 pop count", int'(busy_cnt), mcnt);
  endtask

  task automatic do_ien_set();
    ien_set = 1'b1;
    step();
    ien_set = 1'b0;
    check(txrdy_ien == 1'b1, "R1 ien set while idle", int'(txrdy_ien), 1);
  endtask

  task automatic do_abort(input bit noisy);
    int n = mcnt;
    int k = 0;
    bit seen = 1'b0;
    abort_req = 1'b1;
    step();
    abort_req = 1'b0;
    if (noisy) begin
      bank_commit = 1'b1;
      bank_wdata  = 8'hEE;
      ien_set     = 1'b1;
    end
    for (int g = 0; g < 400 && !seen; g++) begin
      step();
      k++;
      if (k == 1) check(txrdy_ien == 1'b0, "R1 ien masked", int'(txrdy_ien), 0);
      if (n > 0 && k == 3) begin
        check(kill_pend == 1'b1, "R4 kill pending first", int'(kill_pend), 1);
        check(int'(busy_cnt) == n, "R4 count before dec", int'(busy_cnt), n);
      end
      if (n > 0 && k == 4) begin
        check(kill_pend == 1'b1, "R4 kill pending second", int'(kill_pend), 1);
        check(int'(busy_cnt) == n - 1, "R4 count decremented", int'(busy_cnt), n - 1);
      end
      if (n > 0 && k == 5) check(kill_pend == 1'b0, "R4 kill cleared", int'(kill_pend), 0);
      if (abort_done) seen = 1'b1;
    end
    bank_commit = 1'b0;
    ien_set     = 1'b0;
    check(seen, "R3 abort completes", int'(seen), 1);
    check(k == done_latency(n), n == 0 ? "R2 done latency" : "R3 done latency", k, done_latency(n));
    check(int'(busy_cnt) == 0, "R5 empty at done", int'(busy_cnt), 0);
    check(txrdy_ien == 1'b0, "R1 ien_set ignored in abort", int'(txrdy_ien), 0);
    mcnt = 0;
    step();
    check(abort_done == 1'b0, "R7 done one cycle", int'(abort_done), 0);
    check(abort_busy == 1'b0, "R7 back to idle", int'(abort_busy), 0);
    check(int'(busy_cnt) == 0, "R6 no commit during abort", int'(busy_cnt), 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) step();
    rst = 1'b0;
    check(busy_cnt == '0 && txrdy_ien == 1'b0 && kill_pend == 1'b0, "R9 reset state",
          int'(busy_cnt) + int'(txrdy_ien) + int'(kill_pend), 0);
    check(abort_busy == 1'b0 && abort_done == 1'b0 && tx_valid == 1'b0, "R9 reset flags",
          int'(abort_busy) + int'(abort_done) + int'(tx_valid), 0);

    // R2: abort with nothing busy
    do_ien_set();
    do_abort(1'b0);

    // R3/R5/R6: two banks, commits and ien_set held during abort
    do_commit(8'h11);
    do_commit(8'h22);
    do_commit(8'h33);            // full: ignored (R8)
    do_ien_set();
    do_abort(1'b1);

    // R5: order preserved after discard
    do_commit(8'h44);
    do_commit(8'h55);
    do_pop();
    do_pop();
    do_pop();                    // empty pop (R8)

    // one bank then abort
    do_commit(8'h66);
    do_abort(1'b0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int r = int'($urandom % 10);
      if (r < 4)       do_commit(int'($urandom % 256));
      else if (r < 7)  do_pop();
      else if (r == 7) do_ien_set();
      else if (r == 8) do_abort(1'($urandom % 2));
      else             step();
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule